// File: doc/BRIEF.md
# Pointer Version Tag Checker

This block sits between a load/store unit and a small word-organised data memory. Every memory line carries a small version number. Every pointer carries a version number in its top bits. On each load or store, the block compares the two. A matching access completes normally. A mismatched access is blocked: it changes no state and is answered with a fault. This catches code that uses a stale pointer after memory was freed, and code that runs past the end of a buffer into a line holding a different version.

The version bits are stripped from the address before the array is indexed, so they never select a location. Only the low index bits address a line; the bits between the index and the version field are ignored. A separate set-version command writes a new version into a line without any check. The allocator uses it when memory is handed out or reclaimed.

The line's version and its data are read in the same cycle, so the check adds no latency. Every response appears one cycle after its request. The first fault is recorded in a small log: the full pointer, the pointer's version and the line's version. The log holds these values until a clear pulse arrives.

Top module: `ptr_tag_guard`

## Requirements
- R1: After reset, `rsp_valid_o` and `flt_valid_o` are low, every line's version is 0 and every data word is 0. A load or store through a version-0 pointer therefore completes without a fault.
- R2: The line index is taken from `req_addr_i[IDX_W-1:0]` and the pointer version from `req_addr_i[ADDR_W-1 -: TAG_W]` (bits 31:28 by default). Address bits between these two fields do not affect which line is accessed.
- R3: A load (`req_op_i`=0) whose pointer version equals the line's version returns that line's data on `rsp_rdata_o`, with `rsp_fault_o` low.
- R4: A store (`req_op_i`=1) whose pointer version matches writes `req_wdata_i` into the line. It responds with `rsp_fault_o` low and `rsp_rdata_o` zero. A load in the next cycle already sees the new data.
- R5: A load whose pointer version differs from the line's version responds with `rsp_fault_o` high and `rsp_rdata_o` zero.
- R6: A store whose pointer version differs from the line's version responds with `rsp_fault_o` high. It changes neither the line's data nor the line's version.
- R7: A set-version command (`req_op_i`=2) writes `req_tag_i` into the addressed line whatever version the pointer carries. It responds with `rsp_fault_o` low and `rsp_rdata_o` zero.
- R8: Each valid request with `req_op_i` 0, 1 or 2 produces `rsp_valid_o` high exactly one cycle later. A cycle without a request produces `rsp_valid_o` low one cycle later.
- R9: A fault while the log is empty sets `flt_valid_o` in the same cycle as `rsp_fault_o`. It also captures the full pointer on `flt_addr_o`, the pointer's version on `flt_ptr_tag_o` and the line's version on `flt_line_tag_o`. Later faults leave these outputs unchanged.
- R10: Pulsing `flt_clear_i` empties the log one cycle later. If a fault occurs in the same cycle as the clear, the log captures that new fault instead of emptying.
- R11: A request with `req_op_i`=3 is reserved. It produces no response and changes no data and no version.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_op_i | input | 2 | 0 load, 1 store, 2 set version, 3 reserved |
| req_addr_i | input | ADDR_W | Pointer: version in top TAG_W bits, line index in low IDX_W bits |
| req_wdata_i | input | DATA_W | Store data |
| req_tag_i | input | TAG_W | New version for set-version |
| flt_clear_i | input | 1 | Pulse to empty the fault log |
| rsp_valid_o | output | 1 | Response for the previous cycle's request |
| rsp_rdata_o | output | DATA_W | Load data; zero on fault and for non-loads |
| rsp_fault_o | output | 1 | Version mismatch on the previous request |
| flt_valid_o | output | 1 | Fault log holds a record |
| flt_addr_o | output | ADDR_W | Pointer of the logged fault |
| flt_ptr_tag_o | output | TAG_W | Pointer version of the logged fault |
| flt_line_tag_o | output | TAG_W | Line version found for the logged fault |

## Verification
The assertions assume that `req_op_i` and `req_addr_i` hold known values whenever `req_valid_i` is high. They also assume that `flt_clear_i` is driven to a known level on every cycle after reset. The bench drives every input from a single task at the falling edge and never leaves one undriven. Reserved and idle cycles are produced with explicit values, and the walking sequence derives each address and version from a loop index, so no input is ever unknown.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_STORE  = 2'd1,
    OP_SETVER = 2'd2,
    OP_RSVD   = 2'd3
  } ptg_op_e;
endpackage

// File: rtl/ptg_tag_store.sv
module ptg_tag_store #(
  parameter int DEPTH = 16,
  parameter int TAG_W = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [TAG_W-1:0] wtag_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [TAG_W-1:0] rtag_o
);
  logic [TAG_W-1:0] tag_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              tag_q[g] <= '0;
      else if (we_i && widx_i == IDX_W'(g))     tag_q[g] <= wtag_i;
    end
  end

  assign rtag_o = tag_q[ridx_i];
endmodule

// File: rtl/ptg_data_store.sv
module ptg_data_store #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           mem_q[g] <= '0;
      else if (we_i && idx_i == IDX_W'(g))   mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/ptg_fault_log.sv
module ptg_fault_log #(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TAG_W-1:0]  ptag_i,
  input  logic [TAG_W-1:0]  ltag_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [TAG_W-1:0]  ptag_o,
  output logic [TAG_W-1:0]  ltag_o
);
  // a clear frees the log for a fault arriving in the same cycle
  logic take;
  assign take = cap_i && (!valid_o || clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      ptag_o  <= '0;
      ltag_o  <= '0;
    end else if (take) begin
      valid_o <= 1'b1;
      addr_o  <= addr_i;
      ptag_o  <= ptag_i;
      ltag_o  <= ltag_i;
    end else if (clr_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ptr_tag_guard.sv
module ptr_tag_guard
  import ptg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4,
  parameter int DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  input  logic              flt_clear_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_fault_o,
  output logic              flt_valid_o,
  output logic [ADDR_W-1:0] flt_addr_o,
  output logic [TAG_W-1:0]  flt_ptr_tag_o,
  output logic [TAG_W-1:0]  flt_line_tag_o
);
  localparam int IDX_W = $clog2(DEPTH);

  ptg_op_e           op;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  ptr_tag, line_tag;
  logic [DATA_W-1:0] line_data;
  logic              is_ld, is_st, is_sv, tag_ok, fault_now;

  assign op      = ptg_op_e'(req_op_i);
  // version bits never reach the index
  assign idx     = req_addr_i[IDX_W-1:0];
  assign ptr_tag = req_addr_i[ADDR_W-1 -: TAG_W];

  assign is_ld     = req_valid_i && op == OP_LOAD;
  assign is_st     = req_valid_i && op == OP_STORE;
  assign is_sv     = req_valid_i && op == OP_SETVER;
  assign tag_ok    = ptr_tag == line_tag;
  assign fault_now = (is_ld || is_st) && !tag_ok;

  ptg_tag_store #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_tags (
    .clk_i, .rst_ni,
    .we_i   (is_sv),
    .widx_i (idx),
    .wtag_i (req_tag_i),
    .ridx_i (idx),
    .rtag_o (line_tag)
  );

  ptg_data_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_data (
    .clk_i, .rst_ni,
    .we_i    (is_st && tag_ok),
    .idx_i   (idx),
    .wdata_i (req_wdata_i),
    .rdata_o (line_data)
  );

  ptg_fault_log #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_log (
    .clk_i, .rst_ni,
    .cap_i   (fault_now),
    .clr_i   (flt_clear_i),
    .addr_i  (req_addr_i),
    .ptag_i  (ptr_tag),
    .ltag_i  (line_tag),
    .valid_o (flt_valid_o),
    .addr_o  (flt_addr_o),
    .ptag_o  (flt_ptr_tag_o),
    .ltag_o  (flt_line_tag_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= is_ld || is_st || is_sv;
      rsp_fault_o <= fault_now;
      rsp_rdata_o <= (is_ld && tag_ok) ? line_data : '0;
    end
  end
endmodule

// File: rtl/ptg_checker.sv
module ptg_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [1:0]        req_op_i,
  input logic              flt_clear_i,
  input logic              rsp_valid_o,
  input logic [DATA_W-1:0] rsp_rdata_o,
  input logic              rsp_fault_o,
  input logic              flt_valid_o,
  input logic [ADDR_W-1:0] flt_addr_o,
  input logic [TAG_W-1:0]  flt_ptr_tag_o,
  input logic [TAG_W-1:0]  flt_line_tag_o
);
  a_r8_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_op_i != 2'd3 |=> rsp_valid_o);

  a_r8_idle_no_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  a_r11_rsvd_no_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_op_i == 2'd3 |=> !rsp_valid_o);

  a_r5_fault_zero_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> rsp_valid_o && rsp_rdata_o == '0);

  a_r4_nonload_zero_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_op_i != 2'd0 |=> rsp_rdata_o == '0);

  a_r7_setver_no_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_op_i == 2'd2 |=> !rsp_fault_o);

  a_r9_fault_logged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> flt_valid_o);

  a_r9_log_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_valid_o && !flt_clear_i |=> flt_valid_o && $stable(flt_addr_o)
      && $stable(flt_ptr_tag_o) && $stable(flt_line_tag_o));

  a_r10_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_clear_i |=> rsp_fault_o || !flt_valid_o);
endmodule

bind ptr_tag_guard ptg_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_ptg_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_op_i       (req_op_i),
  .flt_clear_i    (flt_clear_i),
  .rsp_valid_o    (rsp_valid_o),
  .rsp_rdata_o    (rsp_rdata_o),
  .rsp_fault_o    (rsp_fault_o),
  .flt_valid_o    (flt_valid_o),
  .flt_addr_o     (flt_addr_o),
  .flt_ptr_tag_o  (flt_ptr_tag_o),
  .flt_line_tag_o (flt_line_tag_o)
);

// File: tb/tb_ptr_tag_guard.sv
`timescale 1ns/1ps
module tb_ptr_tag_guard;
  localparam int ADDR_W = 32, DATA_W = 32, TAG_W = 4, DEPTH = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, flt_clear_i = 1'b0;
  logic [1:0] req_op_i = '0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [DATA_W-1:0] req_wdata_i = '0;
  logic [TAG_W-1:0] req_tag_i = '0;
  logic rsp_valid_o, rsp_fault_o, flt_valid_o;
  logic [DATA_W-1:0] rsp_rdata_o;
  logic [ADDR_W-1:0] flt_addr_o;
  logic [TAG_W-1:0] flt_ptr_tag_o, flt_line_tag_o;

  always #2.5 clk_i = ~clk_i;

  ptr_tag_guard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .DEPTH(DEPTH)) dut (.*);

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // reference state
  logic [DATA_W-1:0] m_data [DEPTH];
  logic [TAG_W-1:0]  m_tag  [DEPTH];
  logic e_fv; logic [ADDR_W-1:0] e_fa; logic [TAG_W-1:0] e_fp, e_fl;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(string req, bit v, logic [1:0] op, logic [ADDR_W-1:0] a,
                      logic [DATA_W-1:0] wd, logic [TAG_W-1:0] nt, bit clr);
    int idx = int'(a[$clog2(DEPTH)-1:0]);
    logic [TAG_W-1:0] pt = a[ADDR_W-1 -: TAG_W];
    logic ev = 0, ef = 0; logic [DATA_W-1:0] er = '0;
    req_valid_i = v; req_op_i = op; req_addr_i = a;
    req_wdata_i = wd; req_tag_i = nt; flt_clear_i = clr;
    if (v && op != 2'd3) begin
      ev = 1;
      if (op == 2'd2) m_tag[idx] = nt;
      else begin
        ef = (pt != m_tag[idx]);
        if (!ef && op == 2'd0) er = m_data[idx];
        if (!ef && op == 2'd1) m_data[idx] = wd;
      end
    end
    if (ef && (!e_fv || clr)) begin
      e_fv = 1; e_fa = a; e_fp = pt; e_fl = m_tag[idx];
    end else if (clr) e_fv = 0;
    @(posedge clk_i); @(negedge clk_i);
    chk(req, "rsp_valid", 64'(rsp_valid_o), 64'(ev));
    chk(req, "rsp_fault", 64'(rsp_fault_o), 64'(ef));
    chk(req, "rsp_rdata", 64'(rsp_rdata_o), 64'(er));
    chk(req, "flt_valid", 64'(flt_valid_o), 64'(e_fv));
    if (e_fv) begin
      chk(req, "flt_addr", 64'(flt_addr_o), 64'(e_fa));
      chk(req, "flt_ptr_tag", 64'(flt_ptr_tag_o), 64'(e_fp));
      chk(req, "flt_line_tag", 64'(flt_line_tag_o), 64'(e_fl));
    end
    req_valid_i = 0; flt_clear_i = 0;
  endtask

  function automatic logic [ADDR_W-1:0] ptr(int t, int mid, int i);
    return {TAG_W'(t), 24'(mid), 4'(i)};
  endfunction

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_data[i] = '0; m_tag[i] = '0; end
    e_fv = 0; e_fa = '0; e_fp = '0; e_fl = '0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", "rsp_valid", 64'(rsp_valid_o), 0);
    chk("R1", "flt_valid", 64'(flt_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    step("R1", 1, 2'd0, ptr(0, 0, 3), '0, '0, 0);
    step("R4", 1, 2'd1, ptr(0, 0, 3), 32'hA5A5_0003, '0, 0);
    step("R3", 1, 2'd0, ptr(0, 0, 3), '0, '0, 0);
    step("R2", 1, 2'd1, ptr(0, 24'hABCDE, 5), 32'h5555_0005, '0, 0);
    step("R2", 1, 2'd0, ptr(0, 24'h12345, 5), '0, '0, 0);
    step("R7", 1, 2'd2, ptr(9, 0, 3), '0, 4'd7, 0);
    step("R5", 1, 2'd0, ptr(0, 24'h77, 3), '0, '0, 0);
    step("R6", 1, 2'd1, ptr(0, 0, 3), 32'hDEAD_BEEF, '0, 0);
    step("R6", 1, 2'd0, ptr(7, 0, 3), '0, '0, 0);
    step("R9", 1, 2'd0, ptr(2, 0, 5), '0, '0, 0);
    step("R10", 0, 2'd0, '0, '0, '0, 1);
    step("R8", 0, 2'd0, '0, '0, '0, 0);
    step("R9", 1, 2'd1, ptr(4, 1, 6), 32'h1, '0, 0);
    step("R10", 1, 2'd0, ptr(1, 2, 3), '0, '0, 1);
    step("R10", 0, 2'd0, '0, '0, '0, 1);
    step("R11", 1, 2'd3, ptr(0, 0, 5), 32'hFFFF_FFFF, 4'd3, 0);
    step("R11", 1, 2'd0, ptr(0, 0, 5), '0, '0, 0);
    // walking mix against the model
    for (int i = 0; i < 96; i++) begin
      step("R8", (i % 7) != 6, 2'(i % 4), ptr((i * 5) % 3, i * 37, (i * 7) % DEPTH),
           32'(i * 32'h0101_0101 + 1), TAG_W'(i % 3), (i % 11) == 10);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule